// File: doc/BRIEF.md
# Two-Shot Edge Capture Unit

This block sits beside a free-running counter and records the counter value at the moment an external pin makes a chosen kind of transition. The pin first passes through a synchronizer. The block keeps the last synchronized level so that it can see rising and falling transitions. Each qualifying transition latches the counter into one of two read-only capture slots.

A small sequence counter lets through at most two captures per armed period. The first capture fills slot one and the second fills slot two. After that, edges are ignored until software clears the capture status or switches the edge selection from off to an active mode. A select input decides which capture produces the one-cycle event strobe: the first or the second. Interrupt aggregation and the counter itself live outside this block.

Top module: `capt_unit`

## Requirements
- R1: The edge selection input `edge_mode_i` is decoded as follows: 0 captures nothing, 1 captures on low-to-high, 2 captures on high-to-low, 3 captures on either transition.
- R2: When `pin_i` changes just before rising clock edge k, the selected slot holds the `cnt_i` value present at edge k+2, and the new value is visible after that edge.
- R3: No capture happens while `pin_dir_in_i` is 0, which marks the pin as an output.
- R4: In an armed period, the first qualifying edge writes slot one (`capt1_o`) and the second writes slot two (`capt2_o`). Every later edge leaves both slots unchanged.
- R5: With `second_sel_i` at 0, `capt_evt_o` pulses high for one cycle together with the first capture. With `second_sel_i` at 1, the pulse comes with the second capture. No other capture produces a pulse.
- R6: A cycle with `capt_clr_i` high returns the sequence to the start, so the next qualifying edge writes slot one. An edge accepted in that same cycle is dropped.
- R7: Moving `edge_mode_i` from 0 to any non-zero value returns the sequence to the start. Changing between non-zero modes does not.
- R8: After reset both slots read 0 and `capt_evt_o` is low. The slots have no write path and change only through captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| cnt_i | input | CNT_W | Value of the free-running counter |
| pin_i | input | 1 | Asynchronous external pin |
| edge_mode_i | input | 2 | Edge selection (0 off, 1 rising, 2 falling, 3 both) |
| pin_dir_in_i | input | 1 | 1 when the pin is configured as an input |
| second_sel_i | input | 1 | 1 makes the event follow the second capture |
| capt_clr_i | input | 1 | Pulse that clears capture status and re-arms |
| capt1_o | output | CNT_W | First capture slot |
| capt2_o | output | CNT_W | Second capture slot |
| capt_evt_o | output | 1 | One-cycle capture event strobe |

## Verification
The bound checker watches several rules on every cycle:
- the sequence count never goes past two;
- a slot changes only while the pin is an input and a mode is active;
- slot two changes only on the capture that fills the sequence;
- the strobe appears only at the position that `second_sel_i` selects;
- a clear or an off-to-on mode change always leaves the sequence at its start.

The bench scenarios are needed for three things. They show that the value stored is the right counter sample after the synchronizer latency. They show that each edge polarity is told apart correctly. They show that edges are really ignored once both slots are full, in the disabled mode, and while the pin is an output.

// File: rtl/capt_pkg.sv
package capt_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;

  localparam int SLOTS = 2;
  localparam int SEQ_W = $clog2(SLOTS + 1);

  // True when the transition prev -> cur matches the selected mode.
  function automatic logic edge_hit(edge_mode_e mode, logic prev, logic cur);
    logic rise;
    logic fall;
    rise = !prev && cur;
    fall = prev && !cur;
    unique case (mode)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_ANY:  edge_hit = rise || fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

  // Position in the sequence (0-based) whose capture raises the event.
  function automatic logic [SEQ_W-1:0] event_slot(logic second_sel);
    event_slot = second_sel ? SEQ_W'(1) : SEQ_W'(0);
  endfunction

  // Sequence restarts when the mode leaves the disabled state.
  function automatic logic leaves_off(edge_mode_e prev_mode, edge_mode_e cur_mode);
    leaves_off = (prev_mode == EDGE_OFF) && (cur_mode != EDGE_OFF);
  endfunction

endpackage

// File: rtl/capt_pin_sync.sv
module capt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_s_o,
  output logic pin_q_o
);

  localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0] chain_q;
  logic             prev_q;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[DEPTH-1];
  end

  assign pin_s_o = chain_q[DEPTH-1];
  assign pin_q_o = prev_q;

endmodule

// File: rtl/capt_edge_det.sv
module capt_edge_det
  import capt_pkg::*;
(
  input  edge_mode_e mode_i,
  input  logic       pin_dir_in_i,
  input  logic       pin_s_i,
  input  logic       pin_q_i,
  output logic       hit_o
);

  always_comb begin
    hit_o = pin_dir_in_i && edge_hit(mode_i, pin_q_i, pin_s_i);
  end

endmodule

// File: rtl/capt_seq.sv
module capt_seq
  import capt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic             restart_i,
  input  logic             second_sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] slot_o [SLOTS],
  output logic             evt_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic             take_o
);

  logic [SEQ_W-1:0] seq_q;
  logic             armed;
  logic             evt_q;

  assign armed  = (seq_q < SEQ_W'(SLOTS));
  assign take_o = hit_i && armed && !restart_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= '0;
      evt_q <= 1'b0;
    end else if (restart_i) begin
      seq_q <= '0;
      evt_q <= 1'b0;
    end else if (take_o) begin
      seq_q <= seq_q + SEQ_W'(1);
      evt_q <= (seq_q == event_slot(second_sel_i));
    end else begin
      evt_q <= 1'b0;
    end
  end

  genvar s;
  generate
    for (s = 0; s < SLOTS; s++) begin : g_slot
      logic [CNT_W-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   val_q <= '0;
        else if (take_o && (seq_q == SEQ_W'(s)))      val_q <= cnt_i;
      end
      assign slot_o[s] = val_q;
    end
  endgenerate

  assign evt_o = evt_q;
  assign seq_o = seq_q;

endmodule

// File: rtl/capt_unit.sv
module capt_unit
  import capt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             pin_i,
  input  logic [1:0]       edge_mode_i,
  input  logic             pin_dir_in_i,
  input  logic             second_sel_i,
  input  logic             capt_clr_i,
  output logic [CNT_W-1:0] capt1_o,
  output logic [CNT_W-1:0] capt2_o,
  output logic             capt_evt_o
);

  edge_mode_e       mode;
  edge_mode_e       mode_q;
  logic             pin_s;
  logic             pin_q;
  logic             hit;
  logic             rearm;
  logic             restart;
  logic             take;
  logic [SEQ_W-1:0] seq_cnt;
  logic [CNT_W-1:0] slots [SLOTS];

  assign mode = edge_mode_e'(edge_mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= EDGE_OFF;
    else        mode_q <= mode;
  end

  assign rearm   = leaves_off(mode_q, mode);
  assign restart = capt_clr_i || rearm;

  capt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (pin_i),
    .pin_s_o (pin_s),
    .pin_q_o (pin_q)
  );

  capt_edge_det u_edge (
    .mode_i       (mode),
    .pin_dir_in_i (pin_dir_in_i),
    .pin_s_i      (pin_s),
    .pin_q_i      (pin_q),
    .hit_o        (hit)
  );

  capt_seq #(.CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_i        (hit),
    .restart_i    (restart),
    .second_sel_i (second_sel_i),
    .cnt_i        (cnt_i),
    .slot_o       (slots),
    .evt_o        (capt_evt_o),
    .seq_o        (seq_cnt),
    .take_o       (take)
  );

  assign capt1_o = slots[0];
  assign capt2_o = slots[1];

endmodule

// File: rtl/capt_unit_chk.sv
module capt_unit_chk
  import capt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       edge_mode_i,
  input logic             pin_dir_in_i,
  input logic             second_sel_i,
  input logic             capt_clr_i,
  input logic [CNT_W-1:0] capt1_o,
  input logic [CNT_W-1:0] capt2_o,
  input logic             capt_evt_o,
  input logic [SEQ_W-1:0] seq_cnt,
  input edge_mode_e       mode_q
);

  // R4: never more than two captures per armed period
  p_seq_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_cnt <= SEQ_W'(SLOTS));

  // R3: a slot only moves while the pin is an input and a mode is active
  p_capt1_input_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (capt1_o != $past(capt1_o)) |-> ($past(pin_dir_in_i) && ($past(edge_mode_i) != 2'd0)));

  p_capt2_input_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (capt2_o != $past(capt2_o)) |-> ($past(pin_dir_in_i) && ($past(edge_mode_i) != 2'd0)));

  // R4: slot two is written only by the capture that completes the sequence
  p_capt2_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (capt2_o != $past(capt2_o)) |-> (seq_cnt == SEQ_W'(2)));

  // R5: the strobe lands at the position chosen by the select input
  p_evt_position_r5: assert property (@(posedge clk) disable iff (!rst_n)
    capt_evt_o |-> (seq_cnt == ($past(second_sel_i) ? SEQ_W'(2) : SEQ_W'(1))));

  // R5: the strobe lasts one cycle
  p_evt_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    capt_evt_o |=> !capt_evt_o);

  // R6: clear restarts the sequence
  p_clear_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(capt_clr_i) |-> (seq_cnt == '0));

  // R7: leaving the disabled mode restarts the sequence
  p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(mode_q) == EDGE_OFF) && ($past(edge_mode_i) != 2'd0)) |-> (seq_cnt == '0));

endmodule

bind capt_unit capt_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .edge_mode_i  (edge_mode_i),
  .pin_dir_in_i (pin_dir_in_i),
  .second_sel_i (second_sel_i),
  .capt_clr_i   (capt_clr_i),
  .capt1_o      (capt1_o),
  .capt2_o      (capt2_o),
  .capt_evt_o   (capt_evt_o),
  .seq_cnt      (seq_cnt),
  .mode_q       (mode_q)
);

// File: tb/tb_capt_unit.sv
module tb_capt_unit;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 32;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic [1:0]       mode;
    logic             sel;
    logic             clr;
    logic             pin;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] exp1;
    logic [CNT_W-1:0] exp2;
    logic             exp_evt;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{2'd1, 1'b0, 1'b0, 1'b1, 32'h100, 32'h100, 32'h000, 1'b1}, // R1 R5 rising, first capture, event
    '{2'd1, 1'b0, 1'b0, 1'b0, 32'h200, 32'h100, 32'h000, 1'b0}, // R1 falling ignored in rising mode
    '{2'd1, 1'b0, 1'b0, 1'b1, 32'h300, 32'h100, 32'h300, 1'b0}, // R4 second capture, no event
    '{2'd1, 1'b0, 1'b0, 1'b0, 32'h400, 32'h100, 32'h300, 1'b0},
    '{2'd1, 1'b0, 1'b0, 1'b1, 32'h500, 32'h100, 32'h300, 1'b0}, // R4 third rise ignored
    '{2'd2, 1'b1, 1'b1, 1'b0, 32'h600, 32'h600, 32'h300, 1'b0}, // R6 clear, falling first
    '{2'd2, 1'b1, 1'b0, 1'b1, 32'h700, 32'h600, 32'h300, 1'b0}, // R1 rise ignored in falling mode
    '{2'd2, 1'b1, 1'b0, 1'b0, 32'h800, 32'h600, 32'h800, 1'b1}, // R5 event on second
    '{2'd3, 1'b1, 1'b1, 1'b1, 32'h900, 32'h900, 32'h800, 1'b0}, // R1 both edges, rise
    '{2'd3, 1'b1, 1'b0, 1'b0, 32'hA00, 32'h900, 32'hA00, 1'b1}, // R1 both edges, fall
    '{2'd0, 1'b1, 1'b0, 1'b1, 32'hB00, 32'h900, 32'hA00, 1'b0}, // R1 disabled
    '{2'd1, 1'b1, 1'b0, 1'b0, 32'hC00, 32'h900, 32'hA00, 1'b0}, // R7 re-armed, fall not selected
    '{2'd1, 1'b1, 1'b0, 1'b1, 32'hD00, 32'hD00, 32'hA00, 1'b0}  // R7 capture into slot one again
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] cnt_i;
  logic             pin_i;
  logic [1:0]       edge_mode_i;
  logic             pin_dir_in_i;
  logic             second_sel_i;
  logic             capt_clr_i;
  logic [CNT_W-1:0] capt1_o;
  logic [CNT_W-1:0] capt2_o;
  logic             capt_evt_o;

  int checks = 0;
  int errors = 0;
  int evt_seen = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capt_unit #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_i        (cnt_i),
    .pin_i        (pin_i),
    .edge_mode_i  (edge_mode_i),
    .pin_dir_in_i (pin_dir_in_i),
    .second_sel_i (second_sel_i),
    .capt_clr_i   (capt_clr_i),
    .capt1_o      (capt1_o),
    .capt2_o      (capt2_o),
    .capt_evt_o   (capt_evt_o)
  );

  always @(negedge clk) begin
    if (capt_evt_o) evt_seen++;
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] mode, input logic sel, input logic clr,
                      input logic pin, input logic [CNT_W-1:0] cnt);
    @(negedge clk);
    edge_mode_i  = mode;
    second_sel_i = sel;
    cnt_i        = cnt;
    capt_clr_i   = clr;
    @(negedge clk);
    capt_clr_i = 1'b0;
    evt_seen   = 0;
    pin_i      = pin;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n        = 1'b0;
    cnt_i        = '0;
    pin_i        = 1'b0;
    edge_mode_i  = 2'd0;
    pin_dir_in_i = 1'b1;
    second_sel_i = 1'b0;
    capt_clr_i   = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 slot one after reset", capt1_o, '0);
    check("R8 slot two after reset", capt2_o, '0);
    check("R8 strobe after reset", {31'd0, capt_evt_o}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i].mode, VEC[i].sel, VEC[i].clr, VEC[i].pin, VEC[i].cnt);
      check($sformatf("R1/R4 vector %0d slot one", i), capt1_o, VEC[i].exp1);
      check($sformatf("R4 vector %0d slot two", i), capt2_o, VEC[i].exp2);
      check($sformatf("R5 vector %0d strobe count", i), evt_seen, {31'd0, VEC[i].exp_evt});
    end

    // R3: pin as output blocks capture (sequence freshly cleared)
    pin_dir_in_i = 1'b0;
    step(2'd3, 1'b0, 1'b1, 1'b0, 32'hE00);
    check("R3 output pin slot one", capt1_o, 32'hD00);
    check("R3 output pin no strobe", evt_seen, 0);
    pin_dir_in_i = 1'b1;
    step(2'd3, 1'b0, 1'b0, 1'b1, 32'hF00);
    check("R3 input again captures", capt1_o, 32'hF00);
    check("R5 strobe on first with select clear", evt_seen, 1);

    // R2: latency, counter changes each cycle after the pin edge
    step(2'd3, 1'b0, 1'b1, 1'b1, 32'h0);
    @(negedge clk);
    pin_i = 1'b0;      // changes before edge k
    cnt_i = 32'h11;    // seen at edge k
    @(negedge clk);
    cnt_i = 32'h22;    // seen at edge k+1
    @(negedge clk);
    cnt_i = 32'h33;    // seen at edge k+2
    @(negedge clk);
    cnt_i = 32'h44;
    repeat (2) @(negedge clk);
    check("R2 counter sample at third edge", capt1_o, 32'h33);

    // R6: clear in the same cycle as an accepted edge drops it
    step(2'd3, 1'b0, 1'b1, 1'b1, 32'h55);   // slot one = 0x55, seq 1
    @(negedge clk);
    pin_i = 1'b0;
    cnt_i = 32'h66;
    repeat (2) @(negedge clk);              // edge now detected, capture pending
    capt_clr_i = 1'b1;
    @(negedge clk);
    capt_clr_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 edge dropped slot two", capt2_o, 32'hA00);
    check("R6 edge dropped slot one", capt1_o, 32'h55);
    step(2'd3, 1'b0, 1'b0, 1'b1, 32'h77);
    check("R6 next edge goes to slot one", capt1_o, 32'h77);

    // R7: non-zero to non-zero mode change does not restart
    step(2'd1, 1'b0, 1'b0, 1'b0, 32'h88);   // seq 1 -> falling not rising: nothing
    step(2'd1, 1'b0, 1'b0, 1'b1, 32'h99);   // second capture
    check("R7 mode change kept sequence, slot two", capt2_o, 32'h99);
    check("R7 slot one unchanged", capt1_o, 32'h77);

    // R8: reset in the middle clears both slots
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 slot one after mid reset", capt1_o, '0);
    check("R8 slot two after mid reset", capt2_o, '0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule